// File: doc/BRIEF.md
# Stereo PDM Microphone Front End

This block serves two digital microphones that share one data wire. It produces the microphone bit clock from the system clock. It captures the shared line once in each half of that clock and steers each bit to the left or the right path. A polarity input selects which clock level carries the left channel. Each path is reduced by a three-stage cascaded integrator-comb decimator with ratio 64. The result is offset and scaled to a signed 24-bit sample. A zero stream gives the most negative code and an all-ones stream gives the most positive code.

The bit clock is exactly 64 times the output sample rate. A parameter sets the system clock as an even multiple of the bit clock. While the enable is low, the microphone clock stays low and all capture and filter state is cleared. After the enable rises, a full frame of 64 bit-clock periods is collected before any sample appears. The polarity input is taken only at frame boundaries, so a frame is never split between two channel assignments.

Top module: `pdm_stereo_frontend`

## Requirements
- R1: While `mic_clk_en` is 0, `mic_clk` is held at 0.
- R2: While enabled, `mic_clk` has a period of `CLK_DIV` system clocks (default 4), high for `CLK_DIV/2` and low for `CLK_DIV/2`.
- R3: With `left_on_high` = 0, the bit captured at the end of the high phase of `mic_clk` feeds the right channel, and the bit captured at the end of the low phase feeds the left channel.
- R4: With `left_on_high` = 1, the high-phase bit feeds the left channel and the low-phase bit feeds the right channel.
- R5: A change of `left_on_high` in mid-frame takes effect only at the next frame boundary. Outputs settle to the new mapping within four frames.
- R6: `pcm_valid` is a single-cycle pulse that repeats every 64 `mic_clk` periods (64·`CLK_DIV` system clocks) and carries both channels together.
- R7: In steady state, with k ones in every 64 bits of a channel (k = 0..64), the channel's output equals k·2^17 − 2^23 in 24-bit two's complement. The exception is k = 64, which gives 0x7FFFFF. So k = 0 gives 0x800000.
- R8: Raising `mic_clk_en` starts from cleared state. The first `pcm_valid` comes no earlier than 64·`CLK_DIV` system clocks and no later than 64·`CLK_DIV`+4 system clocks after the enable is seen.
- R9: Dropping `mic_clk_en` in the last cycle of a frame suppresses that frame's `pcm_valid`, and no further pulse appears while the enable stays low.
- R10: After reset, `mic_clk`, `pcm_valid`, `pcm_left` and `pcm_right` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mic_clk_en | input | 1 | Runs the microphone clock and the capture path |
| left_on_high | input | 1 | 1: left channel on the high clock level; 0: left on the low level |
| mic_data | input | 1 | Shared 1-bit data line from both microphones |
| mic_clk | output | 1 | Microphone bit clock at 64 times the sample rate |
| pcm_left | output | 24 | Left signed sample |
| pcm_right | output | 24 | Right signed sample |
| pcm_valid | output | 1 | One-cycle strobe marking a new sample pair |

## Verification
Two events can fall in the same cycle: the frame-closing capture that hands the integrator sums to the comb stage, and the deassertion of the enable. The bench lines up with an observed `pcm_valid`. It then counts 64·`CLK_DIV`−2 system clocks and drops the enable in the cycle that holds the frame's last low-phase capture. It then requires that no pulse appears and that the clock stays low. The same frame boundary is also where a pending polarity change is adopted. A change made mid-frame is judged by the channel values once the outputs have settled.

// File: rtl/pdm_fe_pkg.sv
package pdm_fe_pkg;
  localparam int OSR_DEF    = 64;
  localparam int STAGES_DEF = 3;
  localparam int PCM_W_DEF  = 24;

  // capture strobes for the two halves of one microphone clock period
  typedef struct packed {
    logic hi;
    logic lo;
  } phase_stb_t;
endpackage

// File: rtl/pdm_clk_gen.sv
module pdm_clk_gen
  import pdm_fe_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int OSR     = OSR_DEF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_en,
  output logic       mic_clk,
  output phase_stb_t stb,
  output logic       frame_end
);
  localparam int PH_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int BC_W = $clog2(OSR);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_DIV - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(CLK_DIV / 2);
  localparam logic [PH_W-1:0] PH_HI_END = PH_W'(CLK_DIV / 2 - 1);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(OSR - 1);

  logic [PH_W-1:0] ph_q, ph_n;
  logic [BC_W-1:0] bc_q, bc_n;
  logic            clk_q, clk_n;
  logic            run_q;
  logic            run;

  // strobes and frame marker
  always_comb begin
    run       = clk_en && run_q;
    stb.hi    = run && (ph_q == PH_HI_END);
    stb.lo    = run && (ph_q == PH_LAST);
    frame_end = stb.lo && (bc_q == BC_LAST);
  end

  // next state
  always_comb begin
    if (!clk_en) begin
      ph_n = PH_LAST;
    end else if (ph_q == PH_LAST) begin
      ph_n = '0;
    end else begin
      ph_n = ph_q + 1'b1;
    end
    clk_n = clk_en && (ph_n < PH_HALF);
    if (!clk_en) begin
      bc_n = '0;
    end else if (stb.lo) begin
      bc_n = (bc_q == BC_LAST) ? '0 : bc_q + 1'b1;
    end else begin
      bc_n = bc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_LAST;
      bc_q  <= '0;
      clk_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      ph_q  <= ph_n;
      bc_q  <= bc_n;
      clk_q <= clk_n;
      run_q <= clk_en;
    end
  end

  assign mic_clk = clk_q;

  assert_clk_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> !mic_clk);
  assert_hi_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stb.hi |-> mic_clk);
  assert_lo_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stb.lo |-> !mic_clk);
endmodule

// File: rtl/pdm_cic.sv
module pdm_cic
  import pdm_fe_pkg::*;
#(
  parameter int OSR    = OSR_DEF,
  parameter int STAGES = STAGES_DEF,
  parameter int PCM_W  = PCM_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bit_stb,
  input  logic             bit_in,
  input  logic             dump,
  output logic [PCM_W-1:0] pcm
);
  localparam int ACC_W = 1 + STAGES * $clog2(OSR);
  localparam int SHIFT = PCM_W - ACC_W;
  localparam logic [PCM_W-1:0] POS_MAX = {1'b0, {(PCM_W-1){1'b1}}};
  localparam logic [PCM_W-1:0] SIGN_BIT = {1'b1, {(PCM_W-1){1'b0}}};

  logic [ACC_W-1:0] integ_q [STAGES];
  logic [ACC_W-1:0] integ_n [STAGES];
  logic [ACC_W-1:0] dly_q   [STAGES];
  logic [ACC_W-1:0] dly_n   [STAGES];
  logic [ACC_W-1:0] comb    [STAGES];
  logic [PCM_W-1:0] pcm_q, pcm_n, scaled;

  // only the full-scale sum reaches the accumulator MSB
  always_comb begin
    comb[0] = integ_q[STAGES-1] - dly_q[0];
    for (int i = 1; i < STAGES; i++) begin
      comb[i] = comb[i-1] - dly_q[i];
    end
    scaled = {comb[STAGES-1], {SHIFT{1'b0}}};
  end

  always_comb begin
    for (int i = 0; i < STAGES; i++) begin
      integ_n[i] = integ_q[i];
      dly_n[i]   = dly_q[i];
    end
    pcm_n = pcm_q;
    if (bit_stb) begin
      integ_n[0] = integ_q[0] + ACC_W'(bit_in);
      for (int i = 1; i < STAGES; i++) begin
        integ_n[i] = integ_q[i] + integ_q[i-1];
      end
    end
    if (dump) begin
      dly_n[0] = integ_q[STAGES-1];
      for (int i = 1; i < STAGES; i++) begin
        dly_n[i] = comb[i-1];
      end
      pcm_n = comb[STAGES-1][ACC_W-1] ? POS_MAX : (scaled ^ SIGN_BIT);
    end
    if (clr) begin
      for (int i = 0; i < STAGES; i++) begin
        integ_n[i] = '0;
        dly_n[i]   = '0;
      end
      pcm_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        integ_q[i] <= '0;
        dly_q[i]   <= '0;
      end
      pcm_q <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) begin
        integ_q[i] <= integ_n[i];
        dly_q[i]   <= dly_n[i];
      end
      pcm_q <= pcm_n;
    end
  end

  assign pcm = pcm_q;
endmodule

// File: rtl/pdm_stereo_frontend.sv
module pdm_stereo_frontend
  import pdm_fe_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int OSR     = OSR_DEF,
  parameter int STAGES  = STAGES_DEF,
  parameter int PCM_W   = PCM_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mic_clk_en,
  input  logic             left_on_high,
  input  logic             mic_data,
  output logic             mic_clk,
  output logic [PCM_W-1:0] pcm_left,
  output logic [PCM_W-1:0] pcm_right,
  output logic             pcm_valid
);
  localparam int NCH = 2;

  logic [1:0]       rst_sync_q;
  logic             rst_i_n;
  phase_stb_t       stb;
  logic             frame_end;
  logic             pol_q, pol_n;
  logic             dump_q, dump_n;
  logic             valid_q, valid_n;
  logic [NCH-1:0]   ch_stb;
  logic [PCM_W-1:0] ch_pcm [NCH];

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_i_n = rst_sync_q[1];

  pdm_clk_gen #(.CLK_DIV(CLK_DIV), .OSR(OSR)) u_clk_gen (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .clk_en    (mic_clk_en),
    .mic_clk   (mic_clk),
    .stb       (stb),
    .frame_end (frame_end)
  );

  // channel 0 = left, channel 1 = right
  always_comb begin
    ch_stb[0] = pol_q ? stb.hi : stb.lo;
    ch_stb[1] = pol_q ? stb.lo : stb.hi;
    pol_n     = (!mic_clk_en || frame_end) ? left_on_high : pol_q;
    dump_n    = mic_clk_en && frame_end;
    valid_n   = mic_clk_en && dump_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      pol_q   <= 1'b0;
      dump_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      pol_q   <= pol_n;
      dump_q  <= dump_n;
      valid_q <= valid_n;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    pdm_cic #(.OSR(OSR), .STAGES(STAGES), .PCM_W(PCM_W)) u_cic (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .clr     (!mic_clk_en),
      .bit_stb (ch_stb[g]),
      .bit_in  (mic_data),
      .dump    (dump_q && mic_clk_en),
      .pcm     (ch_pcm[g])
    );
  end

  assign pcm_left  = ch_pcm[0];
  assign pcm_right = ch_pcm[1];
  assign pcm_valid = valid_q;

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    pcm_valid |=> !pcm_valid);
  assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    !mic_clk_en |=> !pcm_valid);
  assert_pol_frame_hold_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mic_clk_en && !frame_end) |=> $stable(pol_q));
  assert_one_capture_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(ch_stb));
endmodule

// File: tb/pdm_stereo_frontend_bench.sv
module pdm_stereo_frontend_bench;
  localparam int DIV   = 4;
  localparam int FRAME = 64 * DIV;

  logic        clk;
  logic        rst_n;
  logic        mic_clk_en;
  logic        left_on_high;
  logic        mic_data;
  logic        mic_clk;
  logic [23:0] pcm_left;
  logic [23:0] pcm_right;
  logic        pcm_valid;

  int checks   = 0;
  int failures = 0;
  int kl = 0;
  int kr = 0;
  int mic_idx = 0;
  logic prev_clk = 1'b0;

  pdm_stereo_frontend #(.CLK_DIV(DIV)) u_pdm_stereo_frontend (
    .clk          (clk),
    .rst_n        (rst_n),
    .mic_clk_en   (mic_clk_en),
    .left_on_high (left_on_high),
    .mic_data     (mic_data),
    .mic_clk      (mic_clk),
    .pcm_left     (pcm_left),
    .pcm_right    (pcm_right),
    .pcm_valid    (pcm_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // microphone pair: each talks in its own clock level, k ones per 64 bits
  always @(negedge clk) begin
    logic is_left;
    if (mic_clk && !prev_clk) mic_idx = mic_idx + 1;
    prev_clk = mic_clk;
    is_left  = (mic_clk == left_on_high);
    mic_data <= ((mic_idx % 64) < (is_left ? kl : kr));
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_code(input int k);
    int v;
    if (k >= 64) return 24'h7FFFFF;
    v = k * 131072 - 8388608;
    return v[23:0];
  endfunction

  task automatic wait_valid();
    do @(negedge clk); while (!pcm_valid);
  endtask

  task automatic settle_and_check(input string req, input int l, input int r);
    kl = l;
    kr = r;
    repeat (5) wait_valid();
    chk({req, " left"}, {8'h0, pcm_left}, {8'h0, exp_code(l)});
    chk({req, " right"}, {8'h0, pcm_right}, {8'h0, exp_code(r)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R6 actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cnt;
    int hits;
    rst_n = 1'b0;
    mic_clk_en = 1'b0;
    left_on_high = 1'b0;
    repeat (5) @(negedge clk);
    // R10 reset state
    chk("R10 mic_clk", {31'h0, mic_clk}, 32'h0);
    chk("R10 valid", {31'h0, pcm_valid}, 32'h0);
    chk("R10 left", {8'h0, pcm_left}, 32'h0);
    chk("R10 right", {8'h0, pcm_right}, 32'h0);
    rst_n = 1'b1;

    // R1 clock idle while disabled
    hits = 0;
    repeat (300) begin
      @(negedge clk);
      if (mic_clk || pcm_valid) hits++;
    end
    chk("R1 idle activity", hits, 0);

    // R8 first pulse latency after enable
    mic_clk_en = 1'b1;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!pcm_valid && cnt < 2 * FRAME);
    chk("R8 latency lower", {31'h0, cnt > FRAME}, 32'h1);
    chk("R8 latency upper", {31'h0, cnt <= FRAME + 4}, 32'h1);

    // R2 clock shape
    do @(negedge clk); while (!(mic_clk && !prev_clk));
    cnt = 0;
    while (mic_clk) begin cnt++; @(negedge clk); end
    chk("R2 high width", cnt, DIV / 2);
    cnt = 0;
    while (!mic_clk) begin cnt++; @(negedge clk); end
    chk("R2 low width", cnt, DIV / 2);

    // R6 pulse spacing and width
    wait_valid();
    @(negedge clk);
    chk("R6 width", {31'h0, pcm_valid}, 32'h0);
    cnt = 1;
    while (!pcm_valid) begin @(negedge clk); cnt++; end
    chk("R6 period", cnt, FRAME);

    // R7 and R3: density sweep, left on low level
    for (int k = 0; k <= 64; k++) begin
      settle_and_check("R7 R3 sweep", k, 64 - k);
    end

    // R4 and R5: swap polarity in mid-frame, asymmetric densities
    repeat (37) @(negedge clk);
    left_on_high = 1'b1;
    settle_and_check("R4 R5 swapped", 10, 50);
    settle_and_check("R4 swapped full", 64, 0);
    settle_and_check("R4 swapped mid", 33, 7);

    // R9: drop enable in the frame-closing cycle
    wait_valid();
    repeat (FRAME - 2) @(negedge clk);
    mic_clk_en = 1'b0;
    hits = 0;
    repeat (2 * FRAME) begin
      @(negedge clk);
      if (pcm_valid) hits++;
    end
    chk("R9 suppressed pulses", hits, 0);
    chk("R1 clock after drop", {31'h0, mic_clk}, 32'h0);
    chk("R8 cleared output", {8'h0, pcm_left}, 32'h0);

    // R8 restart after re-enable
    mic_clk_en = 1'b1;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!pcm_valid && cnt < 2 * FRAME);
    chk("R8 restart latency", {31'h0, (cnt > FRAME) && (cnt <= FRAME + 4)}, 32'h1);
    settle_and_check("R8 R4 after restart", 20, 44);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule